// File: doc/BRIEF.md
# Interrupt Sampling and Masking Unit

This unit decides, once per completed instruction, whether the core must divert into an exception handler. Two request lines, fast and normal, are active low. Each passes through a clock-domain synchronizer before it is examined. Two internal requesters, a timer and a watchdog, share the fast path. Two abort pulses, one for a data access and one for an instruction fetch, arrive together with the instruction-complete strobe. The unit picks at most one winner at that strobe. On the following cycle it raises a single-cycle take pulse with a 3-bit cause code.

The unit also owns the processor mode and the two interrupt mask bits. Entering an exception moves it into the matching privileged mode and sets the masks that block re-entry. It also records the offset the handler subtracts from the link value on exit. Software changes the masks and the mode through write requests, and these are honoured only outside user mode. The unit is meant to sit beside the core's control sequencer. That sequencer supplies the strobe and consumes the take pulse, cause code and return offset.

Top module: `irq_accept_unit`

## Requirements
- R1: Each request line reaches the decision through SYNC_STAGES (default 2) flip-flops. With the default, a line must be asserted at the input for two rising edges before the edge that samples the strobe, or it is not seen at that boundary.
- R2: No exception is taken in a cycle without the instruction-complete strobe, however long a request is held.
- R3: When several causes are present at one boundary, the winner is chosen in the order data abort, fast interrupt, normal interrupt, prefetch abort. Aborts are never masked.
- R4: Entering any exception sets the normal-interrupt mask. Entering a fast interrupt also sets the fast-interrupt mask. The other exceptions leave the fast-interrupt mask unchanged.
- R5: While the normal mask is 1, a pending normal interrupt is not taken. While the fast mask is 1, a pending fast interrupt is not taken.
- R6: In user mode (mode code 0), mask writes and mode writes are ignored. In any other mode they take effect on the next cycle. A mode write with an unused code (5 to 7) is ignored.
- R7: A high level on the timer request or the watchdog request acts exactly like a low level on the external fast line.
- R8: The return offset output becomes 8 on a data abort and 4 on any other exception. It holds that value until the next exception is taken.
- R9: The take pulse is high for exactly the cycle after an accepting strobe. The cause code is prefetch abort 1, normal 2, fast 3, data abort 4. In that same cycle the mode output shows the matching mode: normal 2, fast 3, abort 4.
- R10: Synchronous active-high reset sets both masks to 1, selects supervisor mode (code 1), clears the take pulse and sets the return offset to 0.
- R11: A mask or mode write presented in the same cycle as an accepting strobe is discarded. After an abort, the masks therefore differ from their old values only by the changes made on entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fiq_n | input | 1 | External fast request, active low, asynchronous |
| irq_n | input | 1 | External normal request, active low, asynchronous |
| tmr_fiq_req | input | 1 | Timer fast request, active high |
| wdt_fiq_req | input | 1 | Watchdog fast request, active high |
| insn_done | input | 1 | Instruction-complete strobe |
| dabt_req | input | 1 | Data abort, valid with the strobe |
| pabt_req | input | 1 | Prefetch abort, valid with the strobe |
| mask_wr_en | input | 1 | Mask write request |
| mask_wr_i | input | 1 | New normal-interrupt mask value |
| mask_wr_f | input | 1 | New fast-interrupt mask value |
| mode_wr_en | input | 1 | Mode write request |
| mode_wr_val | input | 3 | New mode code |
| take_exc | output | 1 | Exception accepted, one-cycle pulse |
| exc_code | output | 3 | Cause of the accepted exception |
| mode_out | output | 3 | Current mode code |
| i_mask | output | 1 | Normal-interrupt mask |
| f_mask | output | 1 | Fast-interrupt mask |
| ret_ofs | output | 4 | Return offset for the last exception |

## Verification
The assertions check on every cycle that a take pulse always follows a strobe and that the mode shown with it matches the cause. They also check that a masked line is never the reported cause, that entry sets the right masks, and that user mode leaves the masks and the mode untouched. Some behaviour is only visible in the directed scenarios. These include the exact synchronizer latency and the ordering among several causes at one boundary. They also include the equivalence of the internal fast requesters with the external line, the dropping of a write that coincides with an abort, and the holding of the return offset across idle cycles.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    localparam int MODE_W = 3;
    localparam int CODE_W = 3;
    localparam int RET_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 3'd0,
        MODE_SVC = 3'd1,
        MODE_IRQ = 3'd2,
        MODE_FIQ = 3'd3,
        MODE_ABT = 3'd4
    } cpu_mode_e;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE = 3'd0,
        EXC_PABT = 3'd1,
        EXC_IRQ  = 3'd2,
        EXC_FIQ  = 3'd3,
        EXC_DABT = 3'd4
    } exc_code_e;

    typedef struct packed {
        logic i_mask;
        logic f_mask;
    } mask_t;

    typedef struct packed {
        logic dabt;
        logic fiq;
        logic irq;
        logic pabt;
    } req_t;

    // Fixed ranking: data abort, fast, normal, prefetch abort.
    function automatic exc_code_e pick_exc(req_t r);
        if (r.dabt)      return EXC_DABT;
        else if (r.fiq)  return EXC_FIQ;
        else if (r.irq)  return EXC_IRQ;
        else if (r.pabt) return EXC_PABT;
        else             return EXC_NONE;
    endfunction

    function automatic cpu_mode_e mode_for(exc_code_e c);
        case (c)
            EXC_FIQ:  return MODE_FIQ;
            EXC_IRQ:  return MODE_IRQ;
            EXC_DABT: return MODE_ABT;
            EXC_PABT: return MODE_ABT;
            default:  return MODE_SVC;
        endcase
    endfunction

    function automatic logic [RET_W-1:0] ret_ofs_for(exc_code_e c);
        return (c == EXC_DABT) ? RET_W'(8) : RET_W'(4);
    endfunction

    function automatic logic is_priv(cpu_mode_e m);
        return m != MODE_USR;
    endfunction

    function automatic logic mode_legal(logic [MODE_W-1:0] v);
        return v <= MODE_W'(MODE_ABT);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import irq_accept_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_done,
    input  logic             dabt_req,
    input  logic             pabt_req,
    input  logic             fiq_lvl,
    input  logic             irq_lvl,
    input  mask_t            masks,
    output logic             accept,
    output exc_code_e        sel,
    output logic             take_q,
    output exc_code_e        code_q,
    output logic [RET_W-1:0] ret_q
);
    req_t req;

    always_comb begin
        req.dabt = insn_done & dabt_req;
        req.fiq  = insn_done & fiq_lvl & ~masks.f_mask;
        req.irq  = insn_done & irq_lvl & ~masks.i_mask;
        req.pabt = insn_done & pabt_req;
        sel      = pick_exc(req);
        accept   = (sel != EXC_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            code_q <= EXC_NONE;
            ret_q  <= '0;
        end else begin
            take_q <= accept;
            if (accept) begin
                code_q <= sel;
                ret_q  <= ret_ofs_for(sel);
            end
        end
    end

    // R9
    take_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> $past(insn_done));

    // R8
    ret_matches_code_chk: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (ret_q == ((code_q == EXC_DABT) ? RET_W'(8) : RET_W'(4))));

    // R5
    fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (take_q && code_q == EXC_FIQ) |-> !$past(masks.f_mask));

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (take_q && code_q == EXC_IRQ) |-> !$past(masks.i_mask));
endmodule

// File: rtl/mask_state.sv
module mask_state
    import irq_accept_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  exc_code_e         sel,
    input  logic              mask_wr_en,
    input  logic              mask_wr_i,
    input  logic              mask_wr_f,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_val,
    output mask_t             masks,
    output cpu_mode_e         mode
);
    mask_t     masks_nx;
    cpu_mode_e mode_nx;
    logic      priv;

    assign priv = is_priv(mode);

    always_comb begin
        masks_nx = masks;
        mode_nx  = mode;
        if (accept) begin
            masks_nx.i_mask = 1'b1;
            if (sel == EXC_FIQ) masks_nx.f_mask = 1'b1;
            mode_nx = mode_for(sel);
        end else begin
            if (mask_wr_en && priv) begin
                masks_nx.i_mask = mask_wr_i;
                masks_nx.f_mask = mask_wr_f;
            end
            if (mode_wr_en && priv && mode_legal(mode_wr_val))
                mode_nx = cpu_mode_e'(mode_wr_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            masks <= '{i_mask: 1'b1, f_mask: 1'b1};
            mode  <= MODE_SVC;
        end else begin
            masks <= masks_nx;
            mode  <= mode_nx;
        end
    end

    // R6
    user_mask_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_USR && mask_wr_en && !accept) |=> $stable(masks));

    // R6
    user_mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_USR && !accept) |=> mode == MODE_USR);

    // R4
    entry_sets_i_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> masks.i_mask);

    // R4
    fiq_entry_sets_f_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && sel == EXC_FIQ) |=> masks.f_mask);

    // R11
    entry_keeps_f_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && sel != EXC_FIQ) |=> masks.f_mask == $past(masks.f_mask));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fiq_n,
    input  logic              irq_n,
    input  logic              tmr_fiq_req,
    input  logic              wdt_fiq_req,
    input  logic              insn_done,
    input  logic              dabt_req,
    input  logic              pabt_req,
    input  logic              mask_wr_en,
    input  logic              mask_wr_i,
    input  logic              mask_wr_f,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_val,
    output logic              take_exc,
    output logic [CODE_W-1:0] exc_code,
    output logic [MODE_W-1:0] mode_out,
    output logic              i_mask,
    output logic              f_mask,
    output logic [RET_W-1:0]  ret_ofs
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lvl;
    logic [LINES-1:0] sync_lvl;
    logic             accept;
    exc_code_e        sel;
    exc_code_e        code_q;
    mask_t            masks;
    cpu_mode_e        mode;

    // Bit 1: fast path (external line low, or either internal source high).
    assign raw_lvl = {~fiq_n | tmr_fiq_req | wdt_fiq_req, ~irq_n};

    line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (sync_lvl)
    );

    exc_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .insn_done (insn_done),
        .dabt_req  (dabt_req),
        .pabt_req  (pabt_req),
        .fiq_lvl   (sync_lvl[1]),
        .irq_lvl   (sync_lvl[0]),
        .masks     (masks),
        .accept    (accept),
        .sel       (sel),
        .take_q    (take_exc),
        .code_q    (code_q),
        .ret_q     (ret_ofs)
    );

    mask_state u_mask (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .sel         (sel),
        .mask_wr_en  (mask_wr_en),
        .mask_wr_i   (mask_wr_i),
        .mask_wr_f   (mask_wr_f),
        .mode_wr_en  (mode_wr_en),
        .mode_wr_val (mode_wr_val),
        .masks       (masks),
        .mode        (mode)
    );

    assign exc_code = code_q;
    assign mode_out = mode;
    assign i_mask   = masks.i_mask;
    assign f_mask   = masks.f_mask;

    // R9
    take_mode_match_chk: assert property (@(posedge clk) disable iff (rst)
        take_exc |-> (mode == mode_for(code_q)));
endmodule

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       fiq_n, irq_n, tmr_fiq_req, wdt_fiq_req;
    logic       insn_done, dabt_req, pabt_req;
    logic       mask_wr_en, mask_wr_i, mask_wr_f;
    logic       mode_wr_en;
    logic [2:0] mode_wr_val;
    logic       take_exc;
    logic [2:0] exc_code;
    logic [2:0] mode_out;
    logic       i_mask, f_mask;
    logic [3:0] ret_ofs;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (
        .clk(clk), .rst(rst), .fiq_n(fiq_n), .irq_n(irq_n),
        .tmr_fiq_req(tmr_fiq_req), .wdt_fiq_req(wdt_fiq_req),
        .insn_done(insn_done), .dabt_req(dabt_req), .pabt_req(pabt_req),
        .mask_wr_en(mask_wr_en), .mask_wr_i(mask_wr_i), .mask_wr_f(mask_wr_f),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .take_exc(take_exc), .exc_code(exc_code), .mode_out(mode_out),
        .i_mask(i_mask), .f_mask(f_mask), .ret_ofs(ret_ofs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fiq_n = 1'b1; irq_n = 1'b1; tmr_fiq_req = 1'b0; wdt_fiq_req = 1'b0;
        insn_done = 1'b0; dabt_req = 1'b0; pabt_req = 1'b0;
        mask_wr_en = 1'b0; mask_wr_i = 1'b0; mask_wr_f = 1'b0;
        mode_wr_en = 1'b0; mode_wr_val = 3'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_mask(input logic wi, input logic wf);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_i = wi; mask_wr_f = wf;
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    task automatic write_mode(input logic [2:0] m);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_val = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    task automatic wait_sync();
        repeat (3) @(negedge clk);
    endtask

    // Strobe for one cycle; on return the cycle after the strobe is current.
    task automatic boundary(input logic d, input logic p, input logic wen,
                            input logic wi, input logic wf, input logic men,
                            input logic [2:0] mv);
        @(negedge clk);
        insn_done = 1'b1; dabt_req = d; pabt_req = p;
        mask_wr_en = wen; mask_wr_i = wi; mask_wr_f = wf;
        mode_wr_en = men; mode_wr_val = mv;
        @(negedge clk);
        insn_done = 1'b0; dabt_req = 1'b0; pabt_req = 1'b0;
        mask_wr_en = 1'b0; mode_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 take", take_exc, 0);
        chk("R10 i_mask", i_mask, 1);
        chk("R10 f_mask", f_mask, 1);
        chk("R10 mode", mode_out, 1);
        chk("R10 ret", ret_ofs, 0);
    endtask

    task automatic t_fiq_entry();
        do_reset();
        write_mask(1'b0, 1'b0);
        fiq_n = 1'b0;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R9 take", take_exc, 1);
        chk("R9 code", exc_code, 3);
        chk("R9 mode", mode_out, 3);
        chk("R4 i after fiq", i_mask, 1);
        chk("R4 f after fiq", f_mask, 1);
        chk("R8 ret fiq", ret_ofs, 4);
        @(negedge clk);
        chk("R9 single pulse", take_exc, 0);
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R5 f blocks fiq", take_exc, 0);
    endtask

    task automatic t_irq_entry();
        do_reset();
        write_mask(1'b0, 1'b0);
        irq_n = 1'b0;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R9 irq code", exc_code, 2);
        chk("R9 irq mode", mode_out, 2);
        chk("R4 i after irq", i_mask, 1);
        chk("R4 f kept after irq", f_mask, 0);
    endtask

    task automatic t_masking();
        do_reset();
        fiq_n = 1'b0; irq_n = 1'b0;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R5 both masked", take_exc, 0);
        write_mask(1'b0, 1'b1);
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R5 fiq masked irq taken", take_exc, 1);
        chk("R5 code irq", exc_code, 2);
    endtask

    task automatic t_priority();
        do_reset();
        write_mask(1'b0, 1'b0);
        fiq_n = 1'b0; irq_n = 1'b0;
        wait_sync();
        boundary(1, 1, 0, 0, 0, 0, 3'd0);
        chk("R3 dabt wins", exc_code, 4);
        chk("R8 ret dabt", ret_ofs, 8);
        chk("R9 abort mode", mode_out, 4);
        chk("R4 f kept after abort", f_mask, 0);

        do_reset();
        write_mask(1'b0, 1'b0);
        fiq_n = 1'b0; irq_n = 1'b0;
        wait_sync();
        boundary(0, 1, 0, 0, 0, 0, 3'd0);
        chk("R3 fiq over irq and pabt", exc_code, 3);

        do_reset();
        write_mask(1'b0, 1'b0);
        irq_n = 1'b0;
        wait_sync();
        boundary(0, 1, 0, 0, 0, 0, 3'd0);
        chk("R3 irq over pabt", exc_code, 2);

        do_reset();
        boundary(0, 1, 0, 0, 0, 0, 3'd0);
        chk("R3 pabt unmasked take", take_exc, 1);
        chk("R3 pabt code", exc_code, 1);
        chk("R8 ret pabt", ret_ofs, 4);
    endtask

    task automatic t_sync_delay();
        do_reset();
        write_mask(1'b0, 1'b0);
        @(negedge clk);
        fiq_n = 1'b0;
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R1 one edge too early", take_exc, 0);
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R1 seen after sync", take_exc, 1);
        chk("R1 code", exc_code, 3);
    endtask

    task automatic t_no_boundary();
        int seen;
        do_reset();
        write_mask(1'b0, 1'b0);
        irq_n = 1'b0;
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (take_exc) seen++;
        end
        chk("R2 no take without strobe", seen, 0);
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R2 take at strobe", take_exc, 1);
    endtask

    task automatic t_internal();
        do_reset();
        write_mask(1'b0, 1'b0);
        tmr_fiq_req = 1'b1;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R7 timer code", exc_code, 3);
        chk("R7 timer take", take_exc, 1);

        do_reset();
        write_mask(1'b0, 1'b0);
        wdt_fiq_req = 1'b1;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R7 watchdog code", exc_code, 3);
    endtask

    task automatic t_user_mode();
        do_reset();
        write_mode(3'd6);
        chk("R6 illegal mode ignored", mode_out, 1);
        write_mask(1'b0, 1'b0);
        write_mode(3'd0);
        chk("R6 enter user", mode_out, 0);
        write_mask(1'b1, 1'b1);
        chk("R6 user i write ignored", i_mask, 0);
        chk("R6 user f write ignored", f_mask, 0);
        write_mode(3'd1);
        chk("R6 user mode write ignored", mode_out, 0);
        irq_n = 1'b0;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R6 irq from user", mode_out, 2);
        irq_n = 1'b1;
        write_mask(1'b0, 1'b0);
        chk("R6 privileged write applies", i_mask, 0);
    endtask

    task automatic t_abort_write();
        do_reset();
        write_mask(1'b0, 1'b0);
        boundary(1, 0, 1, 0, 1, 1, 3'd0);
        chk("R11 abort taken", exc_code, 4);
        chk("R11 f write dropped", f_mask, 0);
        chk("R11 i set by entry", i_mask, 1);
        chk("R11 mode write dropped", mode_out, 4);
    endtask

    task automatic t_ret_hold();
        do_reset();
        write_mask(1'b0, 1'b0);
        boundary(1, 0, 0, 0, 0, 0, 3'd0);
        repeat (5) @(negedge clk);
        chk("R8 ret held", ret_ofs, 8);
        write_mask(1'b0, 1'b0);
        irq_n = 1'b0;
        wait_sync();
        boundary(0, 0, 0, 0, 0, 0, 3'd0);
        chk("R8 ret after irq", ret_ofs, 4);
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        t_reset();
        t_fiq_entry();
        t_irq_entry();
        t_masking();
        t_priority();
        t_sync_delay();
        t_no_boundary();
        t_internal();
        t_user_mode();
        t_abort_write();
        t_ret_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule